// File: doc/BRIEF.md
# ADC Conversion Sequencer with Reference Control

This block is the digital control side of a successive-approximation converter. It holds an input-select register that carries a two-bit reference choice, a result-alignment bit and a three-bit channel number. It times each conversion in ticks of a converter clock enable, raises a sticky done flag and an interrupt, and presents the latest 10-bit sample in a 16-bit view. The view is padded either on the right or on the left, depending on the alignment bit.

Reference changes are shadowed. A write made while a conversion runs is held in a pending field and reaches the active reference output only on the completion edge. The conversion after any reference change is a long one. The alignment bit acts on the view at once. A one-cycle sleep-entry pulse from the core can start a conversion when the controls allow it. A conversion started this way raises a wake output as well as the interrupt when it finishes. The analog front end is replaced by a digital `sample_in` bus, which is captured on the last tick.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset, `sel_rdata`, `ctl_rdata`, `data_view`, `ref_code` and `channel` are all zero, and `busy`, `irq` and `wake` are low.
- R2: `sel_rdata` reads {pending reference [7:6], align [5], 2'b00 [4:3], channel [2:0]}. A write to the select register updates the channel output on the next edge.
- R3: A reference write while idle reaches `ref_code` on the same edge. The codes are 0 supply, 1 external pin, 2 internal without bypass, 3 internal with bypass.
- R4: A reference write during a conversion leaves `ref_code` unchanged until the edge that completes that conversion. On that edge `ref_code` takes the written code.
- R5: A conversion lasts 13 ticks of `adc_tick`. The first conversion started after any change of the active reference lasts 25 ticks.
- R6: `sample_in` is captured on the final tick. With align = 0 the view is {6'b0, result}; with align = 1 it is {result, 6'b0}.
- R7: Changing the align bit changes `data_view` on the next edge, even mid-conversion, and leaves the stored result unchanged.
- R8: `ctl_rdata` reads {enable [7], busy [6], hold mode [5], done flag [4], int enable [3], 3'b000}. A control write with bits 7 and 6 both set starts a conversion when idle. Such a write is ignored while busy: the running conversion keeps its original end.
- R9: The done flag is set on the completion edge and stays set until a control write with bit 4 = 1. A write with bit 4 = 0 leaves the flag unchanged.
- R10: A `sleep_pulse` starts a conversion only if enable = 1, the block is idle, hold mode = 0 and int enable = 1.
- R11: `irq` equals done flag AND int enable. `wake` is high when `irq` is high and the completed conversion was started by `sleep_pulse`. `wake` drops when the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_tick | input | 1 | Converter clock enable, one pulse per converter cycle |
| sel_wr | input | 1 | Write strobe for the input-select register |
| sel_wdata | input | 8 | Input-select write data |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data |
| sleep_pulse | input | 1 | One-cycle pulse on entry into low-noise sleep |
| sample_in | input | 10 | Digital stand-in for the converter output |
| sel_rdata | output | 8 | Input-select register readback |
| ctl_rdata | output | 8 | Control and status readback |
| data_view | output | 16 | Aligned result |
| ref_code | output | 2 | Active reference selection |
| channel | output | 3 | Selected input channel |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Completion interrupt |
| wake | output | 1 | Wake request after a sleep-started conversion |

## Verification
Register writes and start requests take effect on the edge that samples them, so the bench drives on the falling edge and reads one falling edge later. Completion lands on the edge that samples the 13th or 25th tick. On that same edge `busy` falls, the flag, `irq` and `wake` rise, and the shadowed reference reaches `ref_code`. The bench counts ticks one at a time and compares the count at the first cycle where `busy` is low. Alignment changes are checked one cycle after the write, while the conversion is still running.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    parameter int RES_W    = 10;
    parameter int VIEW_W   = 16;
    parameter int CH_W     = 3;
    parameter int NORM_CYC = 13;
    parameter int LONG_CYC = 25;

    localparam int CNT_W = $clog2(LONG_CYC);

    // bit positions shared by the register decoders
    localparam int SEL_REF_HI = 7;
    localparam int SEL_REF_LO = 6;
    localparam int SEL_ALIGN  = 5;
    localparam int CTL_EN     = 7;
    localparam int CTL_GO     = 6;
    localparam int CTL_HOLD   = 5;
    localparam int CTL_FLAG   = 4;
    localparam int CTL_IE     = 3;

    typedef enum logic [1:0] {
        REF_SUPPLY    = 2'd0,
        REF_EXT_PIN   = 2'd1,
        REF_INT_NOCAP = 2'd2,
        REF_INT_CAP   = 2'd3
    } ref_sel_e;

    typedef struct packed {
        logic en;
        logic hold;
        logic ie;
    } ctl_bits_t;

    function automatic logic [CNT_W-1:0] conv_limit(input logic long_req);
        return long_req ? CNT_W'(LONG_CYC - 1) : CNT_W'(NORM_CYC - 1);
    endfunction

endpackage

// File: rtl/adc_sel_reg.sv
module adc_sel_reg
    import adc_seq_pkg::*;
#(
    parameter int CHW = CH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [7:0]      wdata,
    input  logic            busy,
    input  logic            done,
    input  logic            start,
    output ref_sel_e        ref_act,
    output ref_sel_e        ref_pend,
    output logic            left_al,
    output logic [CHW-1:0]  chan,
    output logic            long_req
);
    ref_sel_e pend_n;
    logic     can_apply;
    logic     ref_chg;
    logic     long_next;
    logic     unused_sel;

    assign unused_sel = ^wdata[4:3];

    always_comb begin
        pend_n    = wr ? ref_sel_e'(wdata[SEL_REF_HI:SEL_REF_LO]) : ref_pend;
        can_apply = !busy || done;
        ref_chg   = can_apply && (pend_n != ref_act);
        long_req  = long_next || ref_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_act   <= REF_SUPPLY;
            ref_pend  <= REF_SUPPLY;
            left_al   <= 1'b0;
            chan      <= '0;
            long_next <= 1'b0;
        end else begin
            if (wr) begin
                ref_pend <= pend_n;
                left_al  <= wdata[SEL_ALIGN];
                chan     <= wdata[CHW-1:0];
            end
            if (ref_chg)
                ref_act <= pend_n;
            if (start)
                long_next <= 1'b0;
            else if (ref_chg)
                long_next <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic long_req,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign done = busy && tick && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            lim  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            lim  <= conv_limit(long_req);
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
    import adc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [7:0] wdata,
    input  logic      busy,
    input  logic      done,
    input  logic      sleep_pulse,
    output logic      start,
    output ctl_bits_t ctl,
    output logic      flag,
    output logic      irq,
    output logic      wake
);
    logic sw_start;
    logic slp_start;
    logic from_slp;
    logic clr_req;
    logic unused_ctl;

    assign unused_ctl = ^wdata[2:0];

    always_comb begin
        sw_start  = wr && wdata[CTL_EN] && wdata[CTL_GO] && !busy;
        slp_start = sleep_pulse && ctl.en && !busy && !ctl.hold && ctl.ie;
        start     = sw_start || slp_start;
        clr_req   = wr && wdata[CTL_FLAG];
        irq       = flag && ctl.ie;
        wake      = irq && from_slp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            flag     <= 1'b0;
            from_slp <= 1'b0;
        end else begin
            if (wr) begin
                ctl.en   <= wdata[CTL_EN];
                ctl.hold <= wdata[CTL_HOLD];
                ctl.ie   <= wdata[CTL_IE];
            end
            if (done)
                flag <= 1'b1;
            else if (clr_req)
                flag <= 1'b0;
            if (start)
                from_slp <= slp_start && !sw_start;
            else if (clr_req && !done)
                from_slp <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_result_view.sv
module adc_result_view
    import adc_seq_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int VW = VIEW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [RW-1:0] sample,
    input  logic          left_al,
    output logic [VW-1:0] view
);
    localparam int PAD = VW - RW;

    logic [RW-1:0] result;

    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (done)
            result <= sample;
    end

    generate
        if (PAD > 0) begin : g_pad
            always_comb begin
                if (left_al)
                    view = {result, {PAD{1'b0}}};
                else
                    view = {{PAD{1'b0}}, result};
            end
        end else begin : g_nopad
            logic unused_al;
            assign unused_al = left_al;
            assign view      = result;
        end
    endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RW  = RES_W,
    parameter int VW  = VIEW_W,
    parameter int CHW = CH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adc_tick,
    input  logic          sel_wr,
    input  logic [7:0]    sel_wdata,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    input  logic          sleep_pulse,
    input  logic [RW-1:0] sample_in,
    output logic [7:0]    sel_rdata,
    output logic [7:0]    ctl_rdata,
    output logic [VW-1:0] data_view,
    output logic [1:0]    ref_code,
    output logic [CHW-1:0] channel,
    output logic          busy,
    output logic          irq,
    output logic          wake
);
    ref_sel_e  ref_act;
    ref_sel_e  ref_pend;
    logic      left_al;
    logic      long_req;
    logic      conv_start;
    logic      conv_done;
    logic      flag;
    ctl_bits_t ctl;

    adc_sel_reg #(.CHW(CHW)) u_sel (
        .clk(clk), .rst(rst), .wr(sel_wr), .wdata(sel_wdata),
        .busy(busy), .done(conv_done), .start(conv_start),
        .ref_act(ref_act), .ref_pend(ref_pend), .left_al(left_al),
        .chan(channel), .long_req(long_req)
    );

    adc_conv_timer u_tmr (
        .clk(clk), .rst(rst), .tick(adc_tick), .start(conv_start),
        .long_req(long_req), .busy(busy), .done(conv_done)
    );

    adc_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
        .busy(busy), .done(conv_done), .sleep_pulse(sleep_pulse),
        .start(conv_start), .ctl(ctl), .flag(flag), .irq(irq), .wake(wake)
    );

    adc_result_view #(.RW(RW), .VW(VW)) u_view (
        .clk(clk), .rst(rst), .done(conv_done), .sample(sample_in),
        .left_al(left_al), .view(data_view)
    );

    always_comb begin
        ref_code  = ref_act;
        sel_rdata = '0;
        sel_rdata[SEL_REF_HI:SEL_REF_LO] = ref_pend;
        sel_rdata[SEL_ALIGN]             = left_al;
        sel_rdata[CHW-1:0]               = channel;
        ctl_rdata = {ctl.en, busy, ctl.hold, flag, ctl.ie, 3'b000};
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic       sleep_pulse,
    input logic       busy,
    input logic       conv_done,
    input logic [1:0] ref_code,
    input logic [7:0] ctl_rdata,
    input logic [7:0] sel_rdata,
    input logic [15:0] data_view,
    input logic       irq,
    input logic       wake
);
    a_r4_ref_shadow: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> $stable(ref_code));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> busy);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[4] && !(ctl_wr && ctl_wdata[4])) |=> ctl_rdata[4]);

    a_r9_flag_on_done: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> ctl_rdata[4]);

    a_r10_sleep_gated: assert property (@(posedge clk) disable iff (rst)
        (sleep_pulse && !busy && !ctl_wr && !ctl_rdata[3]) |=> !busy);

    a_r11_wake_needs_irq: assert property (@(posedge clk) disable iff (rst)
        wake |-> irq);

    a_r6_right_pad: assert property (@(posedge clk) disable iff (rst)
        !sel_rdata[5] |-> (data_view[15:10] == 6'd0));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sleep_pulse(sleep_pulse), .busy(busy), .conv_done(conv_done),
    .ref_code(ref_code), .ctl_rdata(ctl_rdata), .sel_rdata(sel_rdata),
    .data_view(data_view), .irq(irq), .wake(wake)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        adc_tick;
    logic        sel_wr;
    logic [7:0]  sel_wdata;
    logic        ctl_wr;
    logic [7:0]  ctl_wdata;
    logic        sleep_pulse;
    logic [9:0]  sample_in;
    logic [7:0]  sel_rdata;
    logic [7:0]  ctl_rdata;
    logic [15:0] data_view;
    logic [1:0]  ref_code;
    logic [2:0]  channel;
    logic        busy;
    logic        irq;
    logic        wake;

    int n_chk  = 0;
    int n_fail = 0;
    int ticks  = 0;
    logic [1:0] exp_ref;
    logic       exp_long;
    logic [9:0] exp_res;
    logic       exp_al;

    always #4 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .adc_tick(adc_tick), .sel_wr(sel_wr),
        .sel_wdata(sel_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sleep_pulse(sleep_pulse), .sample_in(sample_in),
        .sel_rdata(sel_rdata), .ctl_rdata(ctl_rdata), .data_view(data_view),
        .ref_code(ref_code), .channel(channel), .busy(busy), .irq(irq),
        .wake(wake)
    );

    function automatic logic [15:0] want_view(input logic [9:0] r, input logic al);
        return al ? {r, 6'b0} : {6'b0, r};
    endfunction

    function automatic int want_len(input logic lng);
        return lng ? 25 : 13;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic tick1();
        adc_tick = 1'b1;
        @(negedge clk);
        adc_tick = 1'b0;
        ticks++;
    endtask

    task automatic wsel(input logic [7:0] d);
        sel_wr = 1'b1; sel_wdata = d;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic wctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
        if (d[7] && d[6]) ticks = 0;
    endtask

    task automatic slp();
        sleep_pulse = 1'b1;
        @(negedge clk);
        sleep_pulse = 1'b0;
        ticks = 0;
    endtask

    // model bookkeeping when a conversion begins
    task automatic began(output int len);
        len = want_len(exp_long);
        exp_long = 1'b0;
    endtask

    task automatic run_out(input string req, input int len);
        int guard = 0;
        while (busy && guard < 60) begin
            idle();
            tick1();
            guard++;
        end
        check(req, ticks, len);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int len;
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        rst = 1'b1; adc_tick = 0; sel_wr = 0; sel_wdata = 0; ctl_wr = 0;
        ctl_wdata = 0; sleep_pulse = 0; sample_in = 0;
        exp_ref = 0; exp_long = 0; exp_res = 0; exp_al = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();

        // R1 reset state
        check("R1", {sel_rdata, ctl_rdata, data_view}, 32'h0);
        check("R1", {ref_code, channel, busy, irq, wake}, 32'h0);

        // R2 / R3 idle write, ref 3, align 1, chan 7
        wsel(8'hFF);
        check("R2", sel_rdata, 8'hE7);
        check("R2", channel, 3'd7);
        check("R3", ref_code, 2'd3);
        exp_long = (exp_ref != 2'd3); exp_ref = 2'd3; exp_al = 1'b1;

        // R5 long first conversion, R6 left-aligned capture
        sample_in = 10'h2AB;
        wctl(8'hC0);
        check("R8", busy, 1'b1);
        began(len);
        run_out("R5", len);
        exp_res = 10'h2AB;
        check("R6", data_view, want_view(exp_res, exp_al));
        check("R9", ctl_rdata, 8'h90);
        check("R11", irq, 1'b0);

        // R5 normal length, R9 flag sticky vs clear
        sample_in = 10'h155;
        wctl(8'hC0);
        began(len);
        run_out("R5", len);
        exp_res = 10'h155;
        wctl(8'h80);
        check("R9", ctl_rdata[4], 1'b1);
        wctl(8'h90);
        check("R9", ctl_rdata[4], 1'b0);

        // R4 shadowed ref, R7 align mid-conversion, R8 ignored restart
        sample_in = 10'h3FF;
        wctl(8'hC0);
        began(len);
        repeat (3) begin idle(); tick1(); end
        wsel(8'h42);
        exp_al = 1'b0;
        check("R4", ref_code, 2'd3);
        check("R7", data_view, want_view(exp_res, exp_al));
        check("R2", channel, 3'd2);
        wctl(8'hC0);
        ticks = 3;
        check("R8", busy, 1'b1);
        run_out("R8", len);
        check("R4", ref_code, 2'd1);
        exp_long = 1'b1; exp_ref = 2'd1; exp_res = 10'h3FF;
        check("R6", data_view, want_view(exp_res, exp_al));

        // R10 / R11 sleep-started conversion
        wctl(8'h98);
        sample_in = 10'h0F0;
        slp();
        check("R10", busy, 1'b1);
        began(len);
        run_out("R5", len);
        exp_res = 10'h0F0;
        check("R11", {irq, wake}, 2'b11);
        wctl(8'h98);
        check("R11", {irq, wake}, 2'b00);

        // R10 blocked cases
        wctl(8'hA8); slp(); check("R10", busy, 1'b0);
        wctl(8'h08); slp(); check("R10", busy, 1'b0);
        wctl(8'h80); slp(); check("R10", busy, 1'b0);

        // R10 sleep while busy ignored, R11 no wake
        wctl(8'hC8);
        began(len);
        idle(); tick1();
        slp(); ticks = 1;
        run_out("R10", len);
        check("R11", {irq, wake}, 2'b10);
        wctl(8'h98);

        // random mix
        for (int i = 0; i < 30; i++) begin
            logic [7:0] d;
            logic [9:0] s;
            d = 8'($urandom);
            s = 10'($urandom);
            if (d[0]) begin
                wsel(d);
                exp_long = exp_long | (d[7:6] != exp_ref);
                exp_ref = d[7:6]; exp_al = d[5];
                check("R3", ref_code, exp_ref);
            end
            sample_in = s;
            wctl(8'hC0);
            began(len);
            idle(); tick1();
            if (d[1]) begin
                exp_al = ~exp_al;
                wsel({exp_ref, exp_al, 5'd1});
                check("R7", data_view, want_view(exp_res, exp_al));
            end
            run_out("R5", len);
            exp_res = s;
            check("R6", data_view, want_view(exp_res, exp_al));
            check("R4", ref_code, exp_ref);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule